// File: doc/BRIEF.md
# Accumulator Memory-Reference Instruction Sequencer

This block is the control and datapath core of a small 16-bit accumulator machine. It holds its own word memory and steps through each instruction in fixed timing steps: fetch, decode, an optional indirect address fetch, then execution. It runs the seven memory-reference operations: AND, ADD, load, store, unconditional branch, branch-and-save-return and increment-and-skip-if-zero. Every other instruction word passes through as a no-op. There are no interrupts.

A start pulse points the program counter at a chosen address and clears the step counter. A halt input freezes all state, so a test harness can fill memory through a load port while the core is halted. The program counter, accumulator and carry bit are brought out to pins, and any memory word can be read through a separate peek port. This lets results be compared with a reference model.

Top module: `accseq_core`

## Requirements
- R1: While rst_n is low the program counter, accumulator, carry bit and step counter are all zero.
- R2: A start pulse sampled on a clock edge loads the program counter from start_addr and clears the step counter. The next fetch reads start_addr. The accumulator and carry keep their values. Start takes priority over halt.
- R3: While halt is high and start is low, no register changes and the core writes no memory.
- R4: Instruction word layout: bit 15 is the indirect flag, bits 14:12 are the opcode (0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ) and bits 11:0 are the address. Opcode 7, with either value of bit 15, is a no-op that only advances the program counter.
- R5: The step counter rises by one per clock. Steps 0 and 1 fetch and increment the program counter, step 2 decodes, step 3 resolves the indirect address, and execution starts at step 4. The clock counts per instruction are: opcode 7 takes 4; STA and BUN take 5; AND, ADD, LDA and BSA take 6; ISZ takes 7. The counts are the same for direct and indirect addressing.
- R6: With the indirect flag set, the effective address is bits 11:0 of the memory word at the address field. Otherwise it is the address field itself.
- R7: AND replaces the accumulator with its bitwise AND with the operand at the effective address.
- R8: ADD adds the operand to the accumulator and writes the carry-out to the carry bit. No other instruction changes the carry bit.
- R9: LDA loads the accumulator from the effective address. STA writes the accumulator to the effective address.
- R10: BUN continues execution at the effective address.
- R11: BSA writes the address of the instruction after it, zero-extended to 16 bits, to the effective address. Execution then continues at the effective address plus one.
- R12: ISZ increments the word at the effective address modulo 2^16 and writes it back. When the new value is zero, the next instruction is skipped.
- R13: ld_we writes ld_data to ld_addr on the clock edge and takes precedence over a core write. peek_data shows the word at peek_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load program counter from start_addr, clear step counter |
| start_addr | input | 12 | First instruction address |
| halt | input | 1 | Freeze all state |
| ld_we | input | 1 | Memory load write enable |
| ld_addr | input | 12 | Memory load address |
| ld_data | input | 16 | Memory load data |
| peek_addr | input | 12 | Memory observation address |
| peek_data | output | 16 | Word at peek_addr |
| pc_o | output | 12 | Program counter |
| acc_o | output | 16 | Accumulator |
| carry_o | output | 1 | Carry bit |

## Verification
The bound checker watches several properties on every cycle:
- a start pulse loads the program counter and clears the step counter;
- halt freezes the registers and blocks memory writes;
- the step counter stays within its seven steps and counts up through fetch and decode;
- the program counter increments at step 1;
- memory is written only at step 4 or later;
- the carry bit moves only in the step where ADD finishes.

The arithmetic results, effective address resolution, return-address saving, the ISZ skip and the exact clock count of each opcode can only be shown by the bench's programs. The bench runs each program for the number of cycles its model predicts, then compares the program counter, accumulator, carry and data memory.

// File: rtl/accseq_pkg.sv
package accseq_pkg;

    // Opcode field values (bits 14:12 of an instruction word)
    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_ADD = 3'd1,
        OP_LDA = 3'd2,
        OP_STA = 3'd3,
        OP_BUN = 3'd4,
        OP_BSA = 3'd5,
        OP_ISZ = 3'd6,
        OP_NMR = 3'd7
    } opcode_e;

    // Shared arithmetic unit selections
    typedef enum logic [1:0] {
        ALU_AND,
        ALU_ADD,
        ALU_PASS,
        ALU_INC
    } alu_op_e;

    // Number of timing steps, T0 through T6
    localparam int unsigned N_STEPS = 7;

endpackage

// File: rtl/accseq_alu.sv
module accseq_alu
    import accseq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cout_o
);

    logic [DATA_W:0] sum_w;
    logic [DATA_W:0] inc_w;

    assign sum_w = {1'b0, acc_i} + {1'b0, opnd_i};
    assign inc_w = {1'b0, opnd_i} + {{DATA_W{1'b0}}, 1'b1};

    always_comb begin
        res_o  = opnd_i;
        cout_o = 1'b0;
        case (op_i)
            ALU_AND:  res_o = acc_i & opnd_i;
            ALU_ADD:  {cout_o, res_o} = sum_w;
            ALU_INC:  {cout_o, res_o} = inc_w;
            ALU_PASS: res_o = opnd_i;
            default:  res_o = opnd_i;
        endcase
    end

endmodule

// File: rtl/accseq_step.sv
module accseq_step #(
    parameter int N_STEPS = 7,
    parameter int SC_W    = 3
) (
    input  logic [SC_W-1:0]    sc_i,
    output logic [N_STEPS-1:0] t_o
);

    // One-hot timing signal per step value
    for (genvar i = 0; i < N_STEPS; i++) begin : g_step
        assign t_o[i] = (sc_i == SC_W'(i));
    end

endmodule

// File: rtl/accseq_mem.sv
module accseq_mem #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              ld_we_i,
    input  logic [ADDR_W-1:0] ld_addr_i,
    input  logic [DATA_W-1:0] ld_data_i,
    input  logic [ADDR_W-1:0] peek_addr_i,
    output logic [DATA_W-1:0] peek_data_o
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (ld_we_i) begin
            store_q[ld_addr_i] <= ld_data_i;
        end else if (we_i) begin
            store_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o     = store_q[addr_i];
    assign peek_data_o = store_q[peek_addr_i];

endmodule

// File: rtl/accseq_core.sv
module accseq_core
    import accseq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              halt,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic [ADDR_W-1:0] peek_addr,
    output logic [DATA_W-1:0] peek_data,
    output logic [ADDR_W-1:0] pc_o,
    output logic [DATA_W-1:0] acc_o,
    output logic              carry_o
);

    localparam int SC_W    = $clog2(N_STEPS);
    localparam int OP_LSB  = ADDR_W;
    localparam int OP_MSB  = DATA_W - 2;
    localparam int IND_BIT = DATA_W - 1;
    localparam int PAD_W   = DATA_W - ADDR_W;

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [ADDR_W-1:0] ar;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] dr;
        logic [DATA_W-1:0] ac;
        logic              e;
        logic              ind;
        logic [SC_W-1:0]   sc;
    } regs_t;

    regs_t regs_q, regs_d;

    logic [N_STEPS-1:0] t_w;
    logic [DATA_W-1:0]  mem_rdata;
    logic               mem_we;
    logic [DATA_W-1:0]  mem_wdata;
    opcode_e            op_w;
    alu_op_e            alu_op_w;
    logic [DATA_W-1:0]  alu_res_w;
    logic               alu_cout_w;
    logic [SC_W-1:0]    sc_q;

    assign op_w = opcode_e'(regs_q.ir[OP_MSB:OP_LSB]);
    assign sc_q = regs_q.sc;

    accseq_step #(
        .N_STEPS (N_STEPS),
        .SC_W    (SC_W)
    ) u_step (
        .sc_i (regs_q.sc),
        .t_o  (t_w)
    );

    accseq_mem #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_mem (
        .clk         (clk),
        .addr_i      (regs_q.ar),
        .we_i        (mem_we),
        .wdata_i     (mem_wdata),
        .rdata_o     (mem_rdata),
        .ld_we_i     (ld_we),
        .ld_addr_i   (ld_addr),
        .ld_data_i   (ld_data),
        .peek_addr_i (peek_addr),
        .peek_data_o (peek_data)
    );

    always_comb begin
        case (op_w)
            OP_AND:  alu_op_w = ALU_AND;
            OP_ADD:  alu_op_w = ALU_ADD;
            OP_ISZ:  alu_op_w = ALU_INC;
            default: alu_op_w = ALU_PASS;
        endcase
    end

    accseq_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .op_i   (alu_op_w),
        .acc_i  (regs_q.ac),
        .opnd_i (regs_q.dr),
        .res_o  (alu_res_w),
        .cout_o (alu_cout_w)
    );

    // Next-state computation for every register
    always_comb begin
        regs_d    = regs_q;
        mem_we    = 1'b0;
        mem_wdata = regs_q.ac;

        if (start) begin
            regs_d.pc = start_addr;
            regs_d.sc = '0;
        end else if (!halt) begin
            regs_d.sc = regs_q.sc + 1'b1;

            if (t_w[0]) begin
                // Fetch: address the next instruction
                regs_d.ar = regs_q.pc;
            end

            if (t_w[1]) begin
                // Fetch: capture instruction, advance program counter
                regs_d.ir = mem_rdata;
                regs_d.pc = regs_q.pc + ADDR_W'(1);
            end

            if (t_w[2]) begin
                // Decode: latch indirect flag and address field
                regs_d.ar  = regs_q.ir[ADDR_W-1:0];
                regs_d.ind = regs_q.ir[IND_BIT];
            end

            if (t_w[3]) begin
                if (op_w == OP_NMR) begin
                    regs_d.sc = '0;
                end else if (regs_q.ind) begin
                    regs_d.ar = mem_rdata[ADDR_W-1:0];
                end
            end

            if (t_w[4]) begin
                case (op_w)
                    OP_AND, OP_ADD, OP_LDA, OP_ISZ: begin
                        regs_d.dr = mem_rdata;
                    end
                    OP_STA: begin
                        mem_we    = 1'b1;
                        mem_wdata = regs_q.ac;
                        regs_d.sc = '0;
                    end
                    OP_BUN: begin
                        regs_d.pc = regs_q.ar;
                        regs_d.sc = '0;
                    end
                    OP_BSA: begin
                        mem_we    = 1'b1;
                        mem_wdata = {{PAD_W{1'b0}}, regs_q.pc};
                        regs_d.ar = regs_q.ar + ADDR_W'(1);
                    end
                    default: begin
                        regs_d.sc = '0;
                    end
                endcase
            end

            if (t_w[5]) begin
                case (op_w)
                    OP_AND, OP_LDA: begin
                        regs_d.ac = alu_res_w;
                        regs_d.sc = '0;
                    end
                    OP_ADD: begin
                        regs_d.ac = alu_res_w;
                        regs_d.e  = alu_cout_w;
                        regs_d.sc = '0;
                    end
                    OP_BSA: begin
                        regs_d.pc = regs_q.ar;
                        regs_d.sc = '0;
                    end
                    OP_ISZ: begin
                        regs_d.dr = alu_res_w;
                    end
                    default: begin
                        regs_d.sc = '0;
                    end
                endcase
            end

            if (t_w[6]) begin
                if (op_w == OP_ISZ) begin
                    mem_we    = 1'b1;
                    mem_wdata = regs_q.dr;
                    if (regs_q.dr == '0) begin
                        regs_d.pc = regs_q.pc + ADDR_W'(1);
                    end
                end
                regs_d.sc = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign pc_o    = regs_q.pc;
    assign acc_o   = regs_q.ac;
    assign carry_o = regs_q.e;

endmodule

// File: rtl/accseq_chk.sv
module accseq_chk
    import accseq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 16,
    parameter int SC_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              halt,
    input logic [ADDR_W-1:0] start_addr,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] ac,
    input logic              e,
    input logic [SC_W-1:0]   sc,
    input logic [2:0]        op,
    input logic              mem_we
);

    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (pc == $past(start_addr)) && (sc == '0));

    p_halt_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !start) |=> $stable(pc) && $stable(ac) && $stable(e) && $stable(sc));

    p_halt_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !start) |-> !mem_we);

    p_step_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sc <= SC_W'(N_STEPS - 1));

    p_step_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !halt && (sc < SC_W'(3))) |=> (sc == $past(sc) + SC_W'(1)));

    p_fetch_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !halt && (sc == SC_W'(1))) |=> (pc == $past(pc) + ADDR_W'(1)));

    p_write_exec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (sc >= SC_W'(4)));

    p_carry_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!start && !halt && (sc == SC_W'(5)) && (op == 3'd1)) |=> $stable(e));

endmodule

bind accseq_core accseq_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SC_W   (SC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .halt       (halt),
    .start_addr (start_addr),
    .pc         (pc_o),
    .ac         (acc_o),
    .e          (carry_o),
    .sc         (sc_q),
    .op         (op_w),
    .mem_we     (mem_we)
);

// File: tb/accseq_core_tb.sv
module accseq_core_tb;

    localparam int AW = 12;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          halt = 1'b1;
    logic          ld_we = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [DW-1:0] ld_data = '0;
    logic [AW-1:0] peek_addr = '0;
    logic [DW-1:0] peek_data;
    logic [AW-1:0] pc_o;
    logic [DW-1:0] acc_o;
    logic          carry_o;

    int n_vec = 0;
    int n_bad = 0;

    // Reference model state
    logic [DW-1:0] m [4096];
    logic [DW-1:0] mac = '0;
    logic          me = 1'b0;
    logic [AW-1:0] mpc = '0;

    always #5 clk = ~clk;

    accseq_core u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (start_addr),
        .halt       (halt),
        .ld_we      (ld_we),
        .ld_addr    (ld_addr),
        .ld_data    (ld_data),
        .peek_addr  (peek_addr),
        .peek_data  (peek_data),
        .pc_o       (pc_o),
        .acc_o      (acc_o),
        .carry_o    (carry_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic put(input logic [AW-1:0] a, input logic [DW-1:0] w);
        m[a] = w;
        @(negedge clk);
        ld_we = 1'b1; ld_addr = a; ld_data = w;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic peek_chk(input string tag, input logic [AW-1:0] a, input logic [DW-1:0] exp);
        peek_addr = a;
        #1;
        chk(tag, 32'(peek_data), 32'(exp));
    endtask

    // Instruction-level model: returns clock count up to the self-branch
    task automatic model(input logic [AW-1:0] sa, output int cyc);
        logic [AW-1:0] pc, ea;
        logic [DW-1:0] ir, w;
        logic [2:0]    op;
        logic [DW:0]   s;
        pc = sa; cyc = 0;
        for (int k = 0; k < 400; k++) begin
            ir = m[pc];
            op = ir[14:12];
            ea = ir[15] ? m[ir[11:0]][11:0] : ir[11:0];
            if (op == 3'd4 && ea == pc) break;
            pc = pc + 12'd1;
            case (op)
                3'd0: begin mac = mac & m[ea]; cyc += 6; end
                3'd1: begin s = {1'b0, mac} + {1'b0, m[ea]}; mac = s[15:0]; me = s[16]; cyc += 6; end
                3'd2: begin mac = m[ea]; cyc += 6; end
                3'd3: begin m[ea] = mac; cyc += 5; end
                3'd4: begin pc = ea; cyc += 5; end
                3'd5: begin m[ea] = {4'h0, pc}; pc = ea + 12'd1; cyc += 6; end
                3'd6: begin w = m[ea] + 16'd1; m[ea] = w; if (w == 16'd0) pc = pc + 12'd1; cyc += 7; end
                default: cyc += 4;
            endcase
        end
        mpc = pc;
    endtask

    task automatic run(input logic [AW-1:0] sa, input int cyc);
        @(negedge clk);
        start = 1'b1; halt = 1'b0; start_addr = sa;
        @(negedge clk);
        start = 1'b0;
        repeat (cyc) @(negedge clk);
        halt = 1'b1;
        #1;
    endtask

    task automatic check_state(input string tag);
        chk({tag, " pc"}, 32'(pc_o), 32'(mpc));
        chk({tag, " acc"}, 32'(acc_o), 32'(mac));
        chk({tag, " carry"}, 32'(carry_o), 32'(me));
    endtask

    task automatic exec_prog(input logic [AW-1:0] sa, input string tag);
        int c;
        model(sa, c);
        run(sa, c);
        check_state(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete (all requirements)");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] h_pc;
        logic [DW-1:0] h_ac;
        logic [DW-1:0] h_mem;
        int            c;
        void'($urandom(32'd5150));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 pc", 32'(pc_o), 32'h0);
        chk("R1 acc", 32'(acc_o), 32'h0);
        chk("R1 carry", 32'(carry_o), 32'h0);
        rst_n = 1'b1;

        // R13: load port and peek
        put(12'h7FF, 16'hA5C3);
        peek_chk("R13 load/peek", 12'h7FF, 16'hA5C3);

        // Program A: LDA, ADD with carry, STA, LDA, AND
        put(12'h800, 16'hFFFF); put(12'h801, 16'h0001);
        put(12'h802, 16'h5555); put(12'h803, 16'h0F0F);
        put(12'h100, 16'h2800); put(12'h101, 16'h1801);
        put(12'h102, 16'h3802); put(12'h103, 16'h2803);
        put(12'h104, 16'h0800); put(12'h105, 16'h4105);

        // R5: partial run of 6+6+5 clocks ends right after STA
        run(12'h100, 17);
        chk("R5 pc after 17 clocks", 32'(pc_o), 32'h103);
        peek_chk("R9 STA wrote acc", 12'h802, 16'h0000);
        chk("R8 carry out of ADD", 32'(carry_o), 32'h1);

        // R7/R8/R9 full program
        exec_prog(12'h100, "R7 prog A");
        chk("R7 AND result", 32'(acc_o), 32'h0F0F);
        chk("R2 halt at start address branch", 32'(pc_o), 32'h105);

        // R6: indirect load and store
        put(12'h900, 16'h0805); put(12'h805, 16'h1234);
        put(12'h901, 16'h0806); put(12'h806, 16'h0000);
        put(12'h120, 16'hA900); put(12'h121, 16'hB901); put(12'h122, 16'h4122);
        exec_prog(12'h120, "R6 indirect");
        chk("R6 indirect LDA", 32'(acc_o), 32'h1234);
        peek_chk("R6 indirect STA", 12'h806, 16'h1234);

        // R11/R10: subroutine call and indirect return
        put(12'h807, 16'hBEEF);
        put(12'h200, 16'h5300); put(12'h201, 16'h4201);
        put(12'h300, 16'h0000); put(12'h301, 16'h2807); put(12'h302, 16'hC300);
        exec_prog(12'h200, "R11 BSA");
        peek_chk("R11 saved return", 12'h300, 16'h0201);
        chk("R11 body ran", 32'(acc_o), 32'hBEEF);
        chk("R10 indirect return", 32'(pc_o), 32'h201);

        // R10: direct branch skips over a load
        put(12'h210, 16'h4220); put(12'h211, 16'h2801); put(12'h220, 16'h4220);
        exec_prog(12'h210, "R10 BUN");
        chk("R10 target", 32'(pc_o), 32'h220);
        chk("R10 skipped load", 32'(acc_o), 32'hBEEF);

        // R12: increment to zero skips
        put(12'h810, 16'hFFFF); put(12'h811, 16'h0042);
        put(12'h230, 16'h6810); put(12'h231, 16'h2811);
        put(12'h232, 16'h4232); put(12'h233, 16'h4233);
        exec_prog(12'h230, "R12 skip");
        chk("R12 skip pc", 32'(pc_o), 32'h232);
        chk("R12 skip acc kept", 32'(acc_o), 32'hBEEF);
        peek_chk("R12 wrapped to zero", 12'h810, 16'h0000);
        put(12'h810, 16'h0005);
        exec_prog(12'h230, "R12 noskip");
        chk("R12 noskip load ran", 32'(acc_o), 32'h0042);
        peek_chk("R12 incremented", 12'h810, 16'h0006);

        // R4: opcode 7 words are no-ops, 4 clocks each
        put(12'h240, 16'h7123); put(12'h241, 16'hF800);
        put(12'h242, 16'h7FFF); put(12'h243, 16'h4243);
        run(12'h240, 12);
        chk("R4 no-op pc", 32'(pc_o), 32'h243);
        chk("R4 no-op acc", 32'(acc_o), 32'h0042);
        chk("R8 carry kept by others", 32'(carry_o), 32'h1);

        // R8: ADD without carry clears it
        put(12'h812, 16'h0001); put(12'h250, 16'h1812); put(12'h251, 16'h4251);
        exec_prog(12'h250, "R8 add");
        chk("R8 sum", 32'(acc_o), 32'h0043);
        chk("R8 carry cleared", 32'(carry_o), 32'h0);

        // R3: halt in mid-program freezes state
        put(12'h802, 16'h7777);
        model(12'h100, c);
        @(negedge clk);
        start = 1'b1; halt = 1'b0; start_addr = 12'h100;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        halt = 1'b1;
        #1;
        h_pc = pc_o; h_ac = acc_o;
        peek_addr = 12'h802; #1; h_mem = peek_data;
        repeat (8) @(negedge clk);
        chk("R3 pc frozen", 32'(pc_o), 32'(h_pc));
        chk("R3 acc frozen", 32'(acc_o), 32'(h_ac));
        peek_chk("R3 memory frozen", 12'h802, h_mem);
        halt = 1'b0;
        repeat (c - 10) @(negedge clk);
        halt = 1'b1;
        #1;
        check_state("R3 resumed");
        peek_chk("R3 resumed store", 12'h802, m[12'h802]);

        // R2: start wins over halt, acc untouched
        @(negedge clk);
        start = 1'b1; start_addr = 12'h3AB;
        @(negedge clk);
        start = 1'b0;
        #1;
        chk("R2 start under halt pc", 32'(pc_o), 32'h3AB);
        chk("R2 acc kept", 32'(acc_o), 32'(mac));
        repeat (3) @(negedge clk);
        chk("R2 still halted", 32'(pc_o), 32'h3AB);

        // Random programs over a 16-word data area
        for (int i = 0; i < 16; i++) put(12'h900 + 12'(i), 16'h0800 + 16'(i));
        for (int p = 0; p < 40; p++) begin
            for (int i = 0; i < 16; i++) begin
                logic [DW-1:0] v;
                v = 16'($urandom);
                if ($urandom % 4 == 0) v = 16'hFFFF;
                put(12'h800 + 12'(i), v);
            end
            for (int i = 0; i < 12; i++) begin
                int            sel;
                logic          ind;
                logic [2:0]    opc;
                logic [AW-1:0] a;
                sel = int'($urandom % 6);
                ind = 1'($urandom % 2);
                a   = 12'($urandom % 16);
                case (sel)
                    0: opc = 3'd0;
                    1: opc = 3'd1;
                    2: opc = 3'd2;
                    3: opc = 3'd3;
                    4: opc = 3'd6;
                    default: opc = 3'd7;
                endcase
                a = ind ? (12'h900 + a) : (12'h800 + a);
                put(12'h100 + 12'(i), {ind, opc, a});
            end
            put(12'h10C, 16'h410C);
            put(12'h10D, 16'h410D);
            exec_prog(12'h100, "R5/R7/R9/R12 random");
            for (int i = 0; i < 16; i++)
                peek_chk("R9/R12 random data", 12'h800 + 12'(i), m[12'h800 + 12'(i)]);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule